// File: doc/BRIEF.md
# Cyclic ADC Digit Correction and Result Serializer

This block is the digital back end for a pair of interleaved algorithmic analog-to-digital converters in one pixel. Each conversion step of a converter compares its residue against two thresholds and reports a ternary decision (-1, 0 or +1). Because two thresholds are used, any single decision may be off by one step and later steps make up for it. The block collects the decisions, weights each one by its power of two (most significant first), adds them with a mid-scale offset and clamps the total into a binary code.

The two converters take turns: the digit stream alternates between converter 0 and converter 1, one digit per accepted clock. Each converter keeps its own running sum. The block drives the steering state for the analog side, which is the index of the converter whose digit is due next and a one-hot mark of that converter's step. When a conversion completes, the result is presented once on a parallel port, tagged with its converter. It is also queued and shifted out on a narrow serial lane, in completion order.

Top module: `cadc_corr`

## Requirements
- R1: While `rst` is high at a clock edge, all state is cleared. After that edge `stg_cnv` is 0, `stg_step` is 8'b0000_0001, and `res_vld` and `ser_vld` are 0.
- R2: The digit code on `digit` is 2'b01 for +1, 2'b11 for -1 and 2'b00 for 0. The unused code 2'b10 counts as 0.
- R3: A conversion with digits d0..d7 (d0 first) yields `res_code` = clamp(sum of d_i * 2^(7-i) + 128, 0, 255).
- R4: `res_vld` is high for the one clock that follows the edge accepting the eighth digit of a conversion, and is low otherwise. In that clock `res_cnv` holds the index of the converter that finished.
- R5: Each edge with `digit_vld` high gives its digit to converter `stg_cnv` and then toggles `stg_cnv`. With `digit_vld` low, the state is held and `digit` has no effect on any result.
- R6: `stg_step` is the one-hot index of the next digit due from converter `stg_cnv`. Bit 0 marks the first (most significant) digit, and the index wraps to 0 after the eighth.
- R7: Every result is sent on the serial lane in completion order. Each result takes 4 clocks with `ser_vld` high, `ser_dat` carries code bits [7:6], [5:4], [3:2] and [1:0] in that order, and `ser_tag` holds the converter index.
- R8: A reset in the middle of a conversion discards the partial sums. The next conversion starts on converter 0 and its result does not depend on the digits given before the reset.
- R9: Digit sequences with the same weighted sum give the same code. For example +1,-1,0,... and 0,+1,0,... both give 192.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| digit_vld | input | 1 | A digit is offered this cycle |
| digit | input | 2 | Ternary decision code |
| stg_cnv | output | 1 | Converter whose digit is due next |
| stg_step | output | 8 | One-hot step index of that converter |
| res_vld | output | 1 | Finished result present (one clock) |
| res_cnv | output | 1 | Converter index of the result |
| res_code | output | 8 | Corrected, clamped code |
| ser_vld | output | 1 | Serial beat valid |
| ser_tag | output | 1 | Converter index of the serial frame |
| ser_dat | output | 2 | Serial data, most significant pair first |

## Verification
A running sum that lands on the wrong converter, or a pointer that fails to toggle, shows up in the very next clock as a wrong `stg_cnv` or `stg_step`. It also shows up as a wrong code at the end of the current conversion, at most sixteen accepted digits later. A wrong weight or clamp only shows in `res_code` at completion time, so the vectors cover the extremes, the reserved code and redundant pairs of equal value. A fault in the queue or the shifter appears a few clocks after each result, as a serial frame whose bits, tag or order differ from the parallel port.

// File: rtl/cadc_pkg.sv
package cadc_pkg;

  localparam logic [1:0] DIG_POS = 2'b01;
  localparam logic [1:0] DIG_NEG = 2'b11;

  typedef enum logic [1:0] {
    SER_IDLE  = 2'd0,
    SER_FETCH = 2'd1,
    SER_SHIFT = 2'd2
  } ser_st_t;

  // Ternary decision code to a signed 2-bit value; reserved code maps to zero.
  function automatic logic signed [1:0] dig_value(input logic [1:0] code);
    case (code)
      DIG_POS: return 2'sd1;
      DIG_NEG: return -2'sd1;
      default: return 2'sd0;
    endcase
  endfunction

endpackage

// File: rtl/cadc_seq.sv
module cadc_seq #(
  parameter int NSTEP = 8,
  parameter int NCNV  = 2,
  localparam int SW   = (NSTEP > 1) ? $clog2(NSTEP) : 1,
  localparam int CW   = (NCNV > 1) ? $clog2(NCNV) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [CW-1:0]    ptr,
  output logic             first,
  output logic             last,
  output logic [NSTEP-1:0] step_oh
);

  logic [SW-1:0]    cnt_q   [NCNV];
  logic [SW-1:0]    cnt_nxt [NCNV];
  logic [CW-1:0]    ptr_q, ptr_nxt;
  logic [NSTEP-1:0] oh_q;

  always_comb begin
    ptr_nxt = ptr_q;
    if (adv) ptr_nxt = (ptr_q == CW'(NCNV - 1)) ? '0 : ptr_q + 1'b1;
  end

  for (genvar c = 0; c < NCNV; c++) begin : g_cnt
    always_comb begin
      cnt_nxt[c] = cnt_q[c];
      if (adv && ptr_q == CW'(c))
        cnt_nxt[c] = (cnt_q[c] == SW'(NSTEP - 1)) ? '0 : cnt_q[c] + 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst) cnt_q[c] <= '0;
      else     cnt_q[c] <= cnt_nxt[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      oh_q  <= NSTEP'(1);
    end else begin
      ptr_q <= ptr_nxt;
      oh_q  <= NSTEP'(1) << cnt_nxt[ptr_nxt];
    end
  end

  assign ptr     = ptr_q;
  assign first   = (cnt_q[ptr_q] == '0);
  assign last    = (cnt_q[ptr_q] == SW'(NSTEP - 1));
  assign step_oh = oh_q;

endmodule

// File: rtl/cadc_acc.sv
module cadc_acc #(
  parameter int NSTEP  = 8,
  parameter int OUT_W  = 8,
  parameter int OFFSET = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             first,
  input  logic             last,
  input  logic [1:0]       digit,
  output logic             fin,
  output logic [OUT_W-1:0] fin_code
);
  import cadc_pkg::*;

  localparam int AW    = NSTEP + 2;
  localparam int SUM_W = NSTEP + 3;
  localparam int MAXV  = (1 << OUT_W) - 1;

  logic signed [AW-1:0]    acc_q, nxt;
  logic signed [SUM_W-1:0] sum;
  logic signed [1:0]       dv;

  always_comb begin
    dv  = dig_value(digit);
    nxt = ((first ? AW'(0) : acc_q) <<< 1) + {{(AW-2){dv[1]}}, dv};
    sum = {nxt[AW-1], nxt} + SUM_W'(OFFSET);
    if (sum[SUM_W-1])                 fin_code = '0;
    else if (sum > SUM_W'(MAXV))      fin_code = OUT_W'(MAXV);
    else                              fin_code = sum[OUT_W-1:0];
    fin = en && last;
  end

  always_ff @(posedge clk) begin
    if (rst)          acc_q <= '0;
    else if (en)      acc_q <= last ? '0 : nxt;
  end

endmodule

// File: rtl/cadc_fifo.sv
module cadc_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic [W-1:0]  dout_q;
  logic          do_push, do_pop;

  assign full    = (cnt_q == (AW+1)'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
    if (do_pop)  dout_q    <= mem[rp_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  assign dout = dout_q;

endmodule

// File: rtl/cadc_ser.sv
module cadc_ser #(
  parameter int DW   = 8,
  parameter int TW   = 1,
  parameter int LANE = 2,
  localparam int BEATS = DW / LANE,
  localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            q_empty,
  input  logic [TW+DW-1:0] q_data,
  output logic            q_pop,
  output logic            ser_vld,
  output logic [TW-1:0]   ser_tag,
  output logic [LANE-1:0] ser_dat
);
  import cadc_pkg::*;

  ser_st_t       st_q;
  logic [DW-1:0] sh_q;
  logic [TW-1:0] tag_q;
  logic [BW-1:0] beat_q;
  logic          end_beat;

  assign end_beat = (beat_q == '0);

  always_comb begin
    q_pop = 1'b0;
    if (st_q == SER_IDLE && !q_empty)                 q_pop = 1'b1;
    if (st_q == SER_SHIFT && end_beat && !q_empty)    q_pop = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SER_IDLE;
      sh_q   <= '0;
      tag_q  <= '0;
      beat_q <= '0;
    end else begin
      case (st_q)
        SER_IDLE:  if (q_pop) st_q <= SER_FETCH;
        SER_FETCH: begin
          sh_q   <= q_data[DW-1:0];
          tag_q  <= q_data[TW+DW-1:DW];
          beat_q <= BW'(BEATS - 1);
          st_q   <= SER_SHIFT;
        end
        SER_SHIFT: begin
          sh_q <= sh_q << LANE;
          if (end_beat) st_q <= q_pop ? SER_FETCH : SER_IDLE;
          else          beat_q <= beat_q - 1'b1;
        end
        default: st_q <= SER_IDLE;
      endcase
    end
  end

  assign ser_vld = (st_q == SER_SHIFT);
  assign ser_tag = tag_q;
  assign ser_dat = sh_q[DW-1 -: LANE];

endmodule

// File: rtl/cadc_corr.sv
module cadc_corr #(
  parameter int NSTEP      = 8,
  parameter int NCNV       = 2,
  parameter int OUT_W      = 8,
  parameter int OFFSET     = 128,
  parameter int FIFO_DEPTH = 4,
  parameter int LANE       = 2,
  localparam int CW        = (NCNV > 1) ? $clog2(NCNV) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             digit_vld,
  input  logic [1:0]       digit,
  output logic [CW-1:0]    stg_cnv,
  output logic [NSTEP-1:0] stg_step,
  output logic             res_vld,
  output logic [CW-1:0]    res_cnv,
  output logic [OUT_W-1:0] res_code,
  output logic             ser_vld,
  output logic [CW-1:0]    ser_tag,
  output logic [LANE-1:0]  ser_dat
);

  logic [CW-1:0]    ptr;
  logic             first, last;
  logic [NCNV-1:0]  fin;
  logic [OUT_W-1:0] fin_code [NCNV];
  logic             any_fin;
  logic [CW-1:0]    fin_idx;
  logic [OUT_W-1:0] fin_sel;
  logic             res_vld_q;
  logic [CW-1:0]    res_cnv_q;
  logic [OUT_W-1:0] res_code_q;
  logic             fifo_push, fifo_full, fifo_empty, fifo_pop;
  logic [CW+OUT_W-1:0] fifo_dout;

  cadc_seq #(.NSTEP(NSTEP), .NCNV(NCNV)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .adv     (digit_vld),
    .ptr     (ptr),
    .first   (first),
    .last    (last),
    .step_oh (stg_step)
  );

  for (genvar c = 0; c < NCNV; c++) begin : g_cnv
    cadc_acc #(.NSTEP(NSTEP), .OUT_W(OUT_W), .OFFSET(OFFSET)) u_acc (
      .clk      (clk),
      .rst      (rst),
      .en       (digit_vld && ptr == CW'(c)),
      .first    (first),
      .last     (last),
      .digit    (digit),
      .fin      (fin[c]),
      .fin_code (fin_code[c])
    );
  end

  always_comb begin
    any_fin = 1'b0;
    fin_idx = '0;
    fin_sel = '0;
    for (int c = 0; c < NCNV; c++) begin
      if (fin[c]) begin
        any_fin = 1'b1;
        fin_idx = CW'(c);
        fin_sel = fin_code[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld_q  <= 1'b0;
      res_cnv_q  <= '0;
      res_code_q <= '0;
    end else begin
      res_vld_q <= any_fin;
      if (any_fin) begin
        res_cnv_q  <= fin_idx;
        res_code_q <= fin_sel;
      end
    end
  end

  assign stg_cnv   = ptr;
  assign res_vld   = res_vld_q;
  assign res_cnv   = res_cnv_q;
  assign res_code  = res_code_q;
  assign fifo_push = res_vld_q;

  cadc_fifo #(.W(CW + OUT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (fifo_push),
    .din   ({res_cnv_q, res_code_q}),
    .pop   (fifo_pop),
    .dout  (fifo_dout),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  cadc_ser #(.DW(OUT_W), .TW(CW), .LANE(LANE)) u_ser (
    .clk     (clk),
    .rst     (rst),
    .q_empty (fifo_empty),
    .q_data  (fifo_dout),
    .q_pop   (fifo_pop),
    .ser_vld (ser_vld),
    .ser_tag (ser_tag),
    .ser_dat (ser_dat)
  );

endmodule

// File: rtl/cadc_corr_chk.sv
module cadc_corr_chk #(
  parameter int NSTEP = 8,
  parameter int CW    = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             digit_vld,
  input logic [CW-1:0]    stg_cnv,
  input logic [NSTEP-1:0] stg_step,
  input logic             res_vld,
  input logic [CW-1:0]    res_cnv,
  input logic             ser_vld,
  input logic             fifo_push,
  input logic             fifo_full
);

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (stg_cnv == '0 && stg_step == NSTEP'(1) && !res_vld && !ser_vld));

  p_step_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $countones(stg_step) == 1);

  p_ptr_toggle_r5: assert property (@(posedge clk) disable iff (rst)
    digit_vld |=> stg_cnv != $past(stg_cnv));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !digit_vld |=> ($stable(stg_cnv) && $stable(stg_step) && !res_vld));

  p_result_tag_r4: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> ($past(digit_vld) && res_cnv == $past(stg_cnv)));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    fifo_push |-> !fifo_full);

endmodule

bind cadc_corr cadc_corr_chk #(.NSTEP(NSTEP), .CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .digit_vld (digit_vld),
  .stg_cnv   (stg_cnv),
  .stg_step  (stg_step),
  .res_vld   (res_vld),
  .res_cnv   (res_cnv),
  .ser_vld   (ser_vld),
  .fifo_push (fifo_push),
  .fifo_full (fifo_full)
);

// File: tb/cadc_corr_bench.sv
`timescale 1ns/1ps
module cadc_corr_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       digit_vld = 1'b0;
  logic [1:0] digit = 2'b00;
  logic [0:0] stg_cnv, res_cnv, ser_tag;
  logic [7:0] stg_step, res_code;
  logic       res_vld, ser_vld;
  logic [1:0] ser_dat;

  int nchk = 0, nerr = 0;
  bit done = 0;

  int exp_code [64];
  int exp_tag  [64];
  int nexp = 0;
  int got_code [64];
  int got_tag  [64];
  int ngot = 0;
  int beats = 0;
  logic [7:0] shacc;

  // digit i occupies bits [15-2i -: 2]; d0 first
  localparam logic [15:0] VEC [14] = '{
    16'h0000, 16'h5555, 16'hFFFF, 16'h4000, 16'h7000, 16'h1000, 16'hC000,
    16'hC001, 16'hAAAA, 16'h0001, 16'h3FFF, 16'h4FFF, 16'h1557, 16'hD555
  };

  always #2 clk = ~clk;

  cadc_corr u_cadc_corr (
    .clk(clk), .rst(rst), .digit_vld(digit_vld), .digit(digit),
    .stg_cnv(stg_cnv), .stg_step(stg_step), .res_vld(res_vld),
    .res_cnv(res_cnv), .res_code(res_code), .ser_vld(ser_vld),
    .ser_tag(ser_tag), .ser_dat(ser_dat)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int ref_code(input logic [15:0] v);
    int s = 0;
    for (int i = 0; i < 8; i++) begin
      case (v[15-2*i -: 2])
        2'b01:   s += (1 << (7 - i));
        2'b11:   s -= (1 << (7 - i));
        default: ;
      endcase
    end
    s += 128;
    if (s < 0) s = 0;
    if (s > 255) s = 255;
    return s;
  endfunction

  task automatic put(input logic v, input logic [1:0] d);
    digit_vld = v;
    digit     = d;
    @(negedge clk);
  endtask

  // Interleaved pair: converter 0 takes a, converter 1 takes b.
  task automatic run_pair(input logic [15:0] a, input logic [15:0] b, input bit holes);
    for (int i = 0; i < 8; i++) begin
      for (int c = 0; c < 2; c++) begin
        logic [15:0] v;
        v = (c == 0) ? a : b;
        chk("R5", "stg_cnv", int'(stg_cnv), c);
        chk("R6", "stg_step", int'(stg_step), 1 << i);
        if (holes && (i == 3 || i == 7)) begin
          put(1'b0, 2'b01);
          chk("R5", "stg_cnv held", int'(stg_cnv), c);
          chk("R5", "stg_step held", int'(stg_step), 1 << i);
          chk("R5", "res_vld idle", int'(res_vld), 0);
        end
        put(1'b1, v[15-2*i -: 2]);
        chk("R4", "res_vld", int'(res_vld), (i == 7) ? 1 : 0);
        if (i == 7) begin
          chk("R4", "res_cnv", int'(res_cnv), c);
          chk("R3 R2 R9", "res_code", int'(res_code), ref_code(v));
          exp_code[nexp] = ref_code(v);
          exp_tag[nexp]  = c;
          nexp++;
        end
      end
    end
    digit_vld = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst) beats = 0;
    else if (ser_vld) begin
      shacc = {shacc[5:0], ser_dat};
      beats++;
      if (beats == 4) begin
        if (ngot < 64) begin
          got_code[ngot] = int'(shacc);
          got_tag[ngot]  = int'(ser_tag);
        end
        ngot++;
        beats = 0;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: state after reset
    chk("R1", "stg_cnv", int'(stg_cnv), 0);
    chk("R1", "stg_step", int'(stg_step), 1);
    chk("R1", "res_vld", int'(res_vld), 0);
    chk("R1", "ser_vld", int'(ser_vld), 0);

    // Table walk
    for (int k = 0; k < 14; k += 2) run_pair(VEC[k], VEC[k+1], 1'b0);

    // Literal corners
    chk("R3", "all zero", ref_code(16'h0000), 128);
    chk("R3", "all plus clamp", ref_code(16'h5555), 255);
    chk("R3", "all minus clamp", ref_code(16'hFFFF), 0);
    chk("R9", "redundant pair", ref_code(16'h7000), ref_code(16'h1000));

    // R5: idle cycles with a live code on digit must not disturb results
    run_pair(16'h4FFF, 16'h0001, 1'b1);
    repeat (30) @(negedge clk);

    // R8: reset in the middle of a conversion
    put(1'b1, 2'b01);
    put(1'b1, 2'b11);
    put(1'b1, 2'b01);
    rst = 1'b1;
    digit_vld = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    chk("R8", "stg_cnv after reset", int'(stg_cnv), 0);
    chk("R8", "stg_step after reset", int'(stg_step), 1);
    run_pair(16'h0000, 16'h1000, 1'b0);

    repeat (40) @(negedge clk);
    // R7: serial frames match parallel results in order
    chk("R7", "frame count", ngot, nexp);
    for (int n = 0; n < nexp && n < ngot; n++) begin
      chk("R7", "frame code", got_code[n], exp_code[n]);
      chk("R7", "frame tag", got_tag[n], exp_tag[n]);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL R7 watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

endmodule